// File: doc/BRIEF.md
# DRAM strobe-sequence cycle classifier

This block sits on the device side of an asynchronous DRAM model and works out what kind of memory cycle the controller is running. A fast system clock samples the active-low row strobe, column strobe and write enable, together with the multiplexed address bus. Each strobe goes through a synchroniser before the block looks for edges. From the order of the strobe edges and the level of the write enable, the block tells apart eight kinds of cycle. These are: a read, a write whose enable came before the column strobe, a write whose enable came after it, a refresh of an external row with the column strobe idle, a column-first refresh, a hidden refresh that follows a read, entry into test mode, and self-refresh.

For each row-strobe cycle the block emits one encoded report with a single-clock valid pulse. It also produces latch pulses for the row, column and write data, and it drives the enable that takes the data output out of high impedance. A 12-bit row counter supplies the row for every refresh that does not use the external address. A test-mode flag and a self-refresh flag persist across cycles. The storage array and the analog timing are not modelled.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset every pulse output, `q_oe`, `test_mode`, `self_refresh` and `row_addr` are 0, and the internal row counter starts at 0.
- R2: Each row-strobe cycle produces exactly one `cyc_valid` pulse, one clock wide, when `ras_n` rises. `cyc_type` is encoded as 0 read, 1 early write, 2 delayed write, 3 external-row refresh, 4 column-first refresh, 5 hidden refresh, 6 test entry, 7 self-refresh. A self-refresh reports at entry and not at exit.
- R3: If `cas_n` is low when `ras_n` falls and `we_n` is high, the cycle is type 4. `row_addr` takes the internal counter and ignores `addr`, and the counter then advances by one when `ras_n` rises.
- R4: The internal counter wraps from 4095 to 0.
- R5: If `cas_n` and `we_n` are both low when `ras_n` falls, the cycle is type 6. It sets `test_mode` and also refreshes from the counter, advancing the counter.
- R6: `test_mode` is cleared by a type 4 cycle or a type 3 cycle. Read, write and hidden cycles leave it unchanged.
- R7: A cycle with `cas_n` high throughout is type 3. `row_addr` takes `addr` at the `ras_n` fall, `q_oe` stays 0, and the counter does not move.
- R8: If `we_n` is high at the `cas_n` fall, the cycle is type 0. `col_latch` pulses once, and `q_oe` is 1 while `cas_n` stays low and returns to 0 after `cas_n` rises.
- R9: If `we_n` is low before `cas_n` falls, the cycle is type 1. `data_latch` pulses at the `cas_n` fall, and `q_oe` stays 0 for the whole cycle.
- R10: If `we_n` falls while `cas_n` is already low in a read, the cycle becomes type 2, and `data_latch` pulses once at the `we_n` fall.
- R11: If `cas_n` stays low after a read while `ras_n` rises and falls again, the second cycle is type 5. `row_addr` takes the counter, `q_oe` stays 1 throughout, and the counter advances.
- R12: If `ras_n` and `cas_n` stay low for SREF_CYCLES clocks in a type 4 or type 6 cycle, `self_refresh` sets and a type 7 report is issued. `self_refresh` clears only once both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock pulse marking a cycle report |
| cyc_type | output | 3 | Encoded cycle kind (see R2) |
| row_latch | output | 1 | Pulse when a row is taken |
| row_addr | output | ADDR_W | Row selected for the current cycle |
| col_latch | output | 1 | Pulse when a column address is taken |
| data_latch | output | 1 | Pulse when write data is strobed |
| q_oe | output | 1 | Data output drive enable |
| test_mode | output | 1 | Test mode active |
| self_refresh | output | 1 | Self-refresh active |

## Verification
The assertions assume that every strobe level is held for longer than the synchroniser plus the edge detector. They also assume that `ras_n` and `cas_n` never change in the same clock, and that `addr` is stable around the strobe edges. The directed tasks change only one strobe per step and hold every level for at least three clocks. Cycle orderings therefore reach the classifier exactly as they were driven, and no edge falls between two samples.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   typedef enum logic [2:0] {
      CYC_READ   = 3'd0,
      CYC_EWRITE = 3'd1,
      CYC_DWRITE = 3'd2,
      CYC_ROR    = 3'd3,
      CYC_CBR    = 3'd4,
      CYC_HIDDEN = 3'd5,
      CYC_TEST   = 3'd6,
      CYC_SELF   = 3'd7
   } cyc_t;

   typedef enum logic [1:0] {
      K_IDLE   = 2'd0,
      K_ACCESS = 2'd1,
      K_INTREF = 2'd2
   } kind_t;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/dcc_refresh_ctr.sv
module dcc_refresh_ctr #(
   parameter int ROWS = 4096,
   localparam int RW = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [RW-1:0] ctr
);
   localparam bit POW2 = ((ROWS & (ROWS - 1)) == 0);

   if (POW2) begin : g_natural_wrap
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)   ctr <= '0;
         else if (inc) ctr <= ctr + RW'(1);
   end else begin : g_compare_wrap
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)   ctr <= '0;
         else if (inc) ctr <= (ctr == RW'(ROWS - 1)) ? '0 : ctr + RW'(1);
   end
endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
   import dcc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int RW = 12,
   parameter int SREF_CYCLES = 5000,
   localparam int SW = $clog2(SREF_CYCLES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_q,
   input  logic              cas_q,
   input  logic              we_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [RW-1:0]     ctr,
   output logic              ctr_inc,
   output logic              cyc_valid,
   output cyc_t              cyc_type,
   output logic              row_latch,
   output logic [ADDR_W-1:0] row_addr,
   output logic              col_latch,
   output logic              data_latch,
   output logic              q_oe,
   output logic              test_mode,
   output logic              self_refresh
);
   logic ras_d, cas_d, we_d;
   kind_t kind_q;
   cyc_t ref_type, acc_type;
   logic acc_seen, hidden_arm;
   logic [SW-1:0] sref_cnt;

   wire ras_fall = ras_d & ~ras_q;
   wire ras_rise = ~ras_d & ras_q;
   wire cas_fall = cas_d & ~cas_q;
   wire cas_rise = ~cas_d & cas_q;
   wire we_fall  = we_d & ~we_q;
   wire sref_ok  = (kind_q == K_INTREF) && (ref_type == CYC_CBR || ref_type == CYC_TEST);

   assign ctr_inc = ras_rise && (kind_q == K_INTREF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_d <= 1'b1; cas_d <= 1'b1; we_d <= 1'b1;
         kind_q <= K_IDLE; ref_type <= CYC_CBR; acc_type <= CYC_ROR;
         acc_seen <= 1'b0; hidden_arm <= 1'b0; sref_cnt <= '0;
         cyc_valid <= 1'b0; cyc_type <= CYC_READ;
         row_latch <= 1'b0; row_addr <= '0; col_latch <= 1'b0; data_latch <= 1'b0;
         q_oe <= 1'b0; test_mode <= 1'b0; self_refresh <= 1'b0;
      end else begin
         ras_d <= ras_q; cas_d <= cas_q; we_d <= we_q;
         cyc_valid <= 1'b0; row_latch <= 1'b0; col_latch <= 1'b0; data_latch <= 1'b0;

         if (cas_rise)
            q_oe <= 1'b0;
         else if (cas_fall && !ras_q && kind_q == K_ACCESS && we_q)
            q_oe <= 1'b1;

         if (cas_q) hidden_arm <= 1'b0;
         if (ras_q && cas_q) self_refresh <= 1'b0;

         if (ras_fall) begin
            row_latch <= 1'b1;
            sref_cnt  <= '0;
            if (!cas_q) begin
               kind_q   <= K_INTREF;
               row_addr <= ADDR_W'(ctr);
               ref_type <= hidden_arm ? CYC_HIDDEN : (we_q ? CYC_CBR : CYC_TEST);
            end else begin
               kind_q   <= K_ACCESS;
               row_addr <= addr_q;
               acc_seen <= 1'b0;
               acc_type <= CYC_ROR;
            end
         end else if (ras_rise) begin
            kind_q <= K_IDLE;
            if (kind_q == K_INTREF) begin
               if (!self_refresh) begin
                  cyc_valid <= 1'b1;
                  cyc_type  <= ref_type;
               end
               if (ref_type == CYC_TEST)     test_mode <= 1'b1;
               else if (ref_type == CYC_CBR) test_mode <= 1'b0;
            end else if (kind_q == K_ACCESS) begin
               cyc_valid <= 1'b1;
               cyc_type  <= acc_type;
               if (acc_type == CYC_ROR) test_mode <= 1'b0;
               if (acc_type == CYC_READ && !cas_q) hidden_arm <= 1'b1;
            end
         end else if (!ras_q) begin
            if (kind_q == K_ACCESS) begin
               if (cas_fall) begin
                  col_latch <= 1'b1;
                  if (!we_q) data_latch <= 1'b1;
                  if (!acc_seen) begin
                     acc_seen <= 1'b1;
                     acc_type <= we_q ? CYC_READ : CYC_EWRITE;
                  end
               end else if (we_fall && !cas_q && acc_seen) begin
                  data_latch <= 1'b1;
                  if (acc_type == CYC_READ) acc_type <= CYC_DWRITE;
               end
            end else if (sref_ok && !cas_q && !self_refresh) begin
               if (sref_cnt == SW'(SREF_CYCLES - 1)) begin
                  self_refresh <= 1'b1;
                  cyc_valid    <= 1'b1;
                  cyc_type     <= CYC_SELF;
               end else begin
                  sref_cnt <= sref_cnt + SW'(1);
               end
            end
         end
      end
   end
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
   import dcc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int ROWS = 4096,
   parameter int SYNC_STAGES = 2,
   parameter int SREF_CYCLES = 5000,
   localparam int RW = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              cyc_valid,
   output logic [2:0]        cyc_type,
   output logic              row_latch,
   output logic [ADDR_W-1:0] row_addr,
   output logic              col_latch,
   output logic              data_latch,
   output logic              q_oe,
   output logic              test_mode,
   output logic              self_refresh
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RW > ADDR_W) begin : g_bad_rows
      $error("ROWS exceeds the address range");
   end
   if (SREF_CYCLES < 2) begin : g_bad_sref
      $error("SREF_CYCLES must be at least 2");
   end

   logic [2:0]        strobe_s;
   logic [ADDR_W-1:0] addr_s;
   logic              ras_s, cas_s, we_s;
   logic [RW-1:0]     refresh_ctr;
   logic              ctr_inc;
   cyc_t              type_q;

   dcc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strobe (
      .clk(clk), .rst_n(rst_n), .din({ras_n, cas_n, we_n}), .dout(strobe_s));

   dcc_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
      .clk(clk), .rst_n(rst_n), .din(addr), .dout(addr_s));

   assign ras_s = strobe_s[2];
   assign cas_s = strobe_s[1];
   assign we_s  = strobe_s[0];

   dcc_refresh_ctr #(.ROWS(ROWS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .ctr(refresh_ctr));

   dcc_seq #(.ADDR_W(ADDR_W), .RW(RW), .SREF_CYCLES(SREF_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .ras_q(ras_s), .cas_q(cas_s), .we_q(we_s), .addr_q(addr_s),
      .ctr(refresh_ctr), .ctr_inc(ctr_inc),
      .cyc_valid(cyc_valid), .cyc_type(type_q),
      .row_latch(row_latch), .row_addr(row_addr),
      .col_latch(col_latch), .data_latch(data_latch),
      .q_oe(q_oe), .test_mode(test_mode), .self_refresh(self_refresh));

   assign cyc_type = type_q;
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
   parameter int ROWS = 4096,
   localparam int RW = $clog2(ROWS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ras_q,
   input logic          cas_q,
   input logic          cyc_valid,
   input logic [2:0]    cyc_type,
   input logic          q_oe,
   input logic          test_mode,
   input logic          self_refresh,
   input logic [RW-1:0] ctr
);
   assert_oe_needs_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_oe |-> $past(!cas_q));

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |=> !cyc_valid);

   assert_early_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_type == 3'd1) |-> !q_oe);

   assert_ror_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_type == 3'd3) |-> !q_oe);

   assert_test_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_type == 3'd6) |=> test_mode);

   assert_ctr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr != $past(ctr)) |->
         (ctr == (($past(ctr) == RW'(ROWS - 1)) ? '0 : $past(ctr) + RW'(1))));

   assert_sref_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(self_refresh) |-> $past(ras_q && cas_q));
endmodule

bind dram_cycle_classifier dcc_checker #(.ROWS(ROWS)) u_chk (
   .clk(clk), .rst_n(rst_n), .ras_q(ras_s), .cas_q(cas_s),
   .cyc_valid(cyc_valid), .cyc_type(cyc_type), .q_oe(q_oe),
   .test_mode(test_mode), .self_refresh(self_refresh), .ctr(refresh_ctr));

// File: tb/tb_dram_cycle_classifier.sv
module tb_dram_cycle_classifier;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [11:0] addr = '0;
   logic cyc_valid, row_latch, col_latch, data_latch, q_oe, test_mode, self_refresh;
   logic [2:0] cyc_type;
   logic [11:0] row_addr;

   int checks = 0, errors = 0;
   int tot_valid = 0, tot_dl = 0, tot_cl = 0, oe_hits = 0;
   int last_type = -1, last_row = -1;
   int ctr_exp = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dram_cycle_classifier dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
      .cyc_valid(cyc_valid), .cyc_type(cyc_type), .row_latch(row_latch), .row_addr(row_addr),
      .col_latch(col_latch), .data_latch(data_latch), .q_oe(q_oe),
      .test_mode(test_mode), .self_refresh(self_refresh));

   always @(negedge clk) begin
      if (rst_n) begin
         if (cyc_valid) begin tot_valid++; last_type = int'(cyc_type); end
         if (data_latch) tot_dl++;
         if (col_latch) tot_cl++;
         if (row_latch) last_row = int'(row_addr);
         if (q_oe) oe_hits++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic c, input logic w, input int n);
      @(negedge clk);
      ras_n = r; cas_n = c; we_n = w;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(cyc_valid == 0 && row_latch == 0 && col_latch == 0 && data_latch == 0, "R1 pulses", 1, 0);
      chk(q_oe == 0, "R1 q_oe", int'(q_oe), 0);
      chk(test_mode == 0 && self_refresh == 0, "R1 flags", int'({test_mode, self_refresh}), 0);
      chk(row_addr == 0, "R1 row_addr", int'(row_addr), 0);
   endtask

   task automatic t_ror(input logic [11:0] row);
      int v0 = tot_valid, o0 = oe_hits;
      addr = row;
      drive(0, 1, 1, 6);
      drive(1, 1, 1, 6);
      chk(tot_valid == v0 + 1, "R2 one report", tot_valid - v0, 1);
      chk(last_type == 3, "R7 type", last_type, 3);
      chk(last_row == int'(row), "R7 row", last_row, int'(row));
      chk(oe_hits == o0, "R7 hiz", oe_hits - o0, 0);
   endtask

   task automatic t_cbr(input logic w);
      int v0 = tot_valid;
      addr = 12'hABC;
      drive(1, 0, w, 4);
      drive(0, 0, w, 6);
      drive(1, 0, 1, 5);
      drive(1, 1, 1, 5);
      chk(tot_valid == v0 + 1, "R2 one report", tot_valid - v0, 1);
      chk(last_type == (w ? 4 : 6), w ? "R3 type" : "R5 type", last_type, w ? 4 : 6);
      chk(last_row == ctr_exp, w ? "R3 counter row" : "R5 counter row", last_row, ctr_exp);
      ctr_exp = (ctr_exp + 1) % 4096;
   endtask

   task automatic t_read;
      int v0 = tot_valid, c0 = tot_cl;
      addr = 12'h055;
      drive(0, 1, 1, 4);
      drive(0, 0, 1, 6);
      chk(q_oe == 1, "R8 oe while cas low", int'(q_oe), 1);
      drive(0, 1, 1, 6);
      chk(q_oe == 0, "R8 oe after cas high", int'(q_oe), 0);
      drive(1, 1, 1, 6);
      chk(last_type == 0 && tot_valid == v0 + 1, "R8 type", last_type, 0);
      chk(tot_cl == c0 + 1, "R8 col latch", tot_cl - c0, 1);
   endtask

   task automatic t_early;
      int d0 = tot_dl, o0 = oe_hits;
      drive(0, 1, 1, 4);
      drive(0, 1, 0, 4);
      drive(0, 0, 0, 6);
      chk(tot_dl == d0 + 1, "R9 data latch", tot_dl - d0, 1);
      drive(0, 1, 1, 4);
      drive(1, 1, 1, 6);
      chk(last_type == 1, "R9 type", last_type, 1);
      chk(oe_hits == o0, "R9 hiz", oe_hits - o0, 0);
   endtask

   task automatic t_delayed;
      int d0 = tot_dl;
      drive(0, 1, 1, 4);
      drive(0, 0, 1, 6);
      chk(tot_dl == d0, "R10 no latch before we", tot_dl - d0, 0);
      drive(0, 0, 0, 6);
      chk(tot_dl == d0 + 1, "R10 latch at we fall", tot_dl - d0, 1);
      drive(0, 1, 1, 4);
      drive(1, 1, 1, 6);
      chk(last_type == 2, "R10 type", last_type, 2);
   endtask

   task automatic t_hidden;
      int v0 = tot_valid, o0;
      drive(0, 1, 1, 4);
      drive(0, 0, 1, 6);
      drive(1, 0, 1, 6);
      chk(last_type == 0, "R11 leading read", last_type, 0);
      o0 = oe_hits;
      drive(0, 0, 1, 6);
      chk(last_row == ctr_exp, "R11 counter row", last_row, ctr_exp);
      drive(1, 0, 1, 6);
      chk(oe_hits - o0 >= 12 && q_oe == 1, "R11 data held", int'(q_oe), 1);
      chk(last_type == 5 && tot_valid == v0 + 2, "R11 type", last_type, 5);
      ctr_exp = (ctr_exp + 1) % 4096;
      drive(1, 1, 1, 6);
      chk(q_oe == 0, "R8 oe off at end", int'(q_oe), 0);
   endtask

   task automatic t_test_mode;
      t_cbr(1'b0);
      chk(test_mode == 1, "R5 test set", int'(test_mode), 1);
      t_read;
      chk(test_mode == 1, "R6 read keeps test", int'(test_mode), 1);
      t_cbr(1'b1);
      chk(test_mode == 0, "R6 cbr clears test", int'(test_mode), 0);
      t_cbr(1'b0);
      t_ror(12'h3C3);
      chk(test_mode == 0, "R6 ror clears test", int'(test_mode), 0);
   endtask

   task automatic t_self;
      int v0 = tot_valid;
      drive(1, 0, 1, 4);
      drive(0, 0, 1, 5020);
      chk(self_refresh == 1, "R12 entered", int'(self_refresh), 1);
      chk(last_type == 7 && tot_valid == v0 + 1, "R12 type", last_type, 7);
      drive(0, 1, 1, 6);
      chk(self_refresh == 1, "R12 held with ras low", int'(self_refresh), 1);
      drive(1, 1, 1, 6);
      chk(self_refresh == 0, "R12 exit", int'(self_refresh), 0);
      chk(tot_valid == v0 + 1, "R12 no exit report", tot_valid - v0, 1);
      ctr_exp = (ctr_exp + 1) % 4096;
   endtask

   task automatic t_wrap;
      while (ctr_exp != 4095) begin
         drive(1, 0, 1, 3);
         drive(0, 0, 1, 4);
         drive(1, 0, 1, 3);
         drive(1, 1, 1, 3);
         ctr_exp++;
      end
      t_cbr(1'b1);
      chk(ctr_exp == 0, "R4 model wrap", ctr_exp, 0);
      t_cbr(1'b1);
      chk(last_row == 0, "R4 row after wrap", last_row, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_ror(12'h123);
      t_cbr(1'b1);
      t_cbr(1'b1);
      t_read;
      t_early;
      t_delayed;
      t_hidden;
      t_test_mode;
      t_self;
      t_wrap;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule